// File: doc/BRIEF.md
# Polyphase Eighth-Band Decimating FIR

This block low-pass filters a stream of signed samples so that only the lowest eighth of the input band is kept, and emits one filtered sample for every eight it accepts. The 152-tap symmetric response is split into eight polyphase branches of 19 taps each. Each accepted sample is steered to one branch, and that branch refreshes its partial sum at once. Because of this, the block never computes the outputs that decimation would discard.

An upstream source presents a sample with `in_valid` whenever it has one. Gaps of any length are allowed. Downstream logic takes `out_data` in the single cycle that `out_valid` is high. The coefficients come from a closed-form function inside the block, so there is no table to load.

Top module: `poly_decim8_fir`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_data` is 0. Reset restarts sample counting, so the first output follows the 8th sample accepted after release.
- R2: Exactly one output is produced for each 8 accepted samples. `out_valid` is high for one cycle, at the second rising edge after the edge that accepts the 8th sample of a group.
- R3: A cycle with `in_valid` low is ignored. Its `in_data` never reaches any output, and `out_data` holds its value between output pulses.
- R4: Let t be the index of a group's last sample. The output is y(t) = sum over i = 0..151 of c[i]·x[t−i]. Here x is the accepted sample sequence taken as signed 12-bit, and samples before the last reset count as zero.
- R5: The coefficients are c[i] = 16·min(i, 151−i) − 584, so c[i] = c[151−i]. Tap i sits in the branch numbered i mod 8.
- R6: The sum is rounded to the output scale by adding 512 and then shifting arithmetically right by 10 bits, which rounds halves toward plus infinity.
- R7: The rounded value is clamped to the signed 16-bit range [−32768, 32767].
- R8: The internal sum never wraps. An input built to push the sum to its most positive or most negative value yields 32767 or −32768 respectively.
- R9: A reset in the middle of a group discards every stored sample and partial sum. The following outputs depend only on samples accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `in_data` holds a sample to accept |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_data | output | 16 | Signed filtered, decimated sample |

## Verification
A single-sample impulse plays the coefficient set back one decimated point at a time. This exposes a branch wired to the wrong tap group, or a commutator that runs in the wrong direction, because either one scrambles the coefficient order. Sign-matched full-scale blocks drive the sum to both extremes. A narrow accumulator would wrap and return the wrong sign there, and a missing clamp would wrap the output. Random gaps with garbage data on idle cycles catch a design that accepts samples it should not. A reset after five samples of a group catches stale history or a commutator that is not restarted, since either shifts or corrupts every later output.

// File: rtl/fir_decim_pkg.sv
package fir_decim_pkg;

  localparam int COEF_W = 16;

  // Symmetric coefficient rule: rises linearly from the ends toward the centre.
  function automatic int tap_coef(input int idx, input int ntaps);
    int m;
    m = (idx < ntaps - 1 - idx) ? idx : (ntaps - 1 - idx);
    return 16 * m - 584;
  endfunction

  // Round half toward +inf while dropping sh fractional bits.
  function automatic longint round_shift(input longint a, input int sh);
    return (a + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  // Clamp to a signed range of w bits.
  function automatic longint clamp_signed(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/fir_commutator.sv
module fir_commutator #(
  parameter int NPH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic [NPH-1:0] br_we,
  output logic           group_done
);
  localparam int PH_W = $clog2(NPH);

  logic [PH_W-1:0] phase_q;

  // Sample with phase p feeds the branch holding taps (NPH-1-p) mod NPH.
  always_comb begin
    for (int b = 0; b < NPH; b++) begin
      br_we[b] = in_valid && (phase_q == PH_W'(NPH - 1 - b));
    end
  end

  assign group_done = in_valid && (phase_q == PH_W'(NPH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (in_valid) begin
      phase_q <= (phase_q == PH_W'(NPH - 1)) ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/fir_branch.sv
module fir_branch
  import fir_decim_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int ACC_W   = 36,
  parameter int NTAPS   = 152,
  parameter int NPH     = 8,
  parameter int BR      = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic signed [DATA_W-1:0] din,
  output logic        [ACC_W-1:0]  psum
);
  localparam int BR_TAPS = NTAPS / NPH;

  logic signed [DATA_W-1:0] line_q [BR_TAPS];
  logic signed [DATA_W-1:0] line_d [BR_TAPS];
  longint                   mac_v;

  // Contents the line will hold after this write.
  always_comb begin
    line_d[0] = din;
    for (int j = 1; j < BR_TAPS; j++) begin
      line_d[j] = line_q[j-1];
    end
  end

  // Partial sum of this branch's taps BR, BR+NPH, BR+2*NPH, ...
  always_comb begin
    mac_v = 0;
    for (int j = 0; j < BR_TAPS; j++) begin
      mac_v = mac_v + longint'(line_d[j]) * longint'(tap_coef(BR + NPH * j, NTAPS));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < BR_TAPS; j++) line_q[j] <= '0;
      psum <= '0;
    end else if (we) begin
      for (int j = 0; j < BR_TAPS; j++) line_q[j] <= line_d[j];
      psum <= ACC_W'(mac_v);
    end
  end

endmodule

// File: rtl/fir_combine.sv
module fir_combine
  import fir_decim_pkg::*;
#(
  parameter int NPH   = 8,
  parameter int ACC_W = 36,
  parameter int OUT_W = 16,
  parameter int SHIFT = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      group_done,
  input  logic [NPH-1:0][ACC_W-1:0] psum_bus,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_data
);
  logic   fire_q;
  longint total;

  always_comb begin
    total = 0;
    for (int b = 0; b < NPH; b++) begin
      total = total + longint'($signed(psum_bus[b]));
    end
  end

  // fire_q waits one edge so the last branch's partial sum is registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      fire_q    <= group_done;
      out_valid <= fire_q;
      if (fire_q) begin
        out_data <= OUT_W'(clamp_signed(round_shift(total, SHIFT), OUT_W));
      end
    end
  end

endmodule

// File: rtl/poly_decim8_fir.sv
module poly_decim8_fir
  import fir_decim_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16,
  parameter int NTAPS  = 152,
  parameter int NPH    = 8,
  parameter int SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  localparam int ACC_W = DATA_W + COEF_W + $clog2(NTAPS);

  logic [NPH-1:0]            br_we;
  logic                      group_done;
  logic [NPH-1:0][ACC_W-1:0] psum_bus;

  fir_commutator #(.NPH(NPH)) u_comm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .br_we      (br_we),
    .group_done (group_done)
  );

  for (genvar b = 0; b < NPH; b++) begin : g_branch
    fir_branch #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .NTAPS  (NTAPS),
      .NPH    (NPH),
      .BR     (b)
    ) u_br (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (br_we[b]),
      .din   ($signed(in_data)),
      .psum  (psum_bus[b])
    );
  end

  fir_combine #(
    .NPH   (NPH),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .group_done (group_done),
    .psum_bus   (psum_bus),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

endmodule

// File: rtl/fir_decim_checker.sv
module fir_decim_checker #(
  parameter int NPH   = 8,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NPH-1:0]   br_we,
  input logic             group_done,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int PH_W = $clog2(NPH);

  logic [PH_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (in_valid) seen_q <= (seen_q == PH_W'(NPH - 1)) ? '0 : seen_q + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && out_data == '0));

  assert_group_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    group_done == (in_valid && seen_q == PH_W'(NPH - 1)));

  assert_output_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |=> ##1 out_valid);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_one_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_we) && ((|br_we) == in_valid));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind poly_decim8_fir fir_decim_checker #(.NPH(NPH), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .br_we      (br_we),
  .group_done (group_done),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/sim_poly_decim8_fir.sv
module sim_poly_decim8_fir;
  localparam int DW = 12;
  localparam int OW = 16;
  localparam int NT = 152;
  localparam int HMAX = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int     n_tests = 0;
  int     n_fail  = 0;
  int     cyc     = 0;
  bit     finished = 1'b0;
  string  cur_req = "R1";

  int     hist [HMAX];
  int     n_acc = 0;
  longint exp_val [1024];
  int     exp_due [1024];
  int     head = 0;
  int     tail = 0;

  poly_decim8_fir u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // R5: coefficient rule restated from the ends inward.
  function automatic longint bcoef(input int i);
    int d;
    d = (i > NT - 1 - i) ? NT - 1 - i : i;
    return longint'(d) * 16 - 584;
  endfunction

  // R4, R6, R7: direct-form sum, then round half up by 2^10, then clamp.
  function automatic longint model(input int t);
    longint acc;
    longint r;
    acc = 0;
    for (int i = 0; i < NT; i++) begin
      if (t - i >= 0) acc += longint'(hist[t-i]) * bcoef(i);
    end
    r = acc + 512;
    r = (r - (((r % 1024) + 1024) % 1024)) / 1024;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit v, input int d);
    in_valid = v;
    in_data  = DW'(d);
    @(negedge clk);
    if (v) begin
      hist[n_acc] = d;
      if (n_acc % 8 == 7) begin
        exp_val[tail % 1024] = model(n_acc);
        exp_due[tail % 1024] = cyc + 1;
        tail++;
      end
      n_acc++;
    end
    in_valid = 1'b0;
  endtask

  task automatic pad_group();
    while (n_acc % 8 != 0) send(1'b1, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    n_acc = 0;
    head = tail;
    rst_n = 1'b1;
  endtask

  task automatic run_random(input int count);
    bit v;
    int d;
    for (int k = 0; k < count; k++) begin
      v = ($urandom_range(0, 9) < 7);
      d = int'($urandom_range(0, 4095)) - 2048;
      send(v, d);
    end
  endtask

  // Output monitor: value and cycle of every pulse (R2, plus the current phase tag).
  always @(negedge clk) begin
    if (rst_n) begin
      if (head != tail && exp_due[head % 1024] < cyc) begin
        check(1'b0, "R2 missing output", cyc, exp_due[head % 1024]);
        head++;
      end
      if (out_valid) begin
        if (head == tail) begin
          check(1'b0, "R2 unexpected output", cyc, -1);
        end else begin
          check(exp_due[head % 1024] == cyc, "R2 output cycle", cyc, exp_due[head % 1024]);
          check(longint'($signed(out_data)) == exp_val[head % 1024], cur_req,
                longint'($signed(out_data)), exp_val[head % 1024]);
          head++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    // R1: quiet outputs during reset
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_data == '0, "R1 data in reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 after release", out_data, 0);

    // R4/R5/R6: impulse replays the coefficient set
    cur_req = "R5 impulse";
    send(1'b1, 2047);
    for (int k = 0; k < 167; k++) send(1'b1, 0);
    cur_req = "R6 odd impulse";
    send(1'b1, -3);
    for (int k = 0; k < 167; k++) send(1'b1, 0);

    // R4: constant input
    cur_req = "R4 constant";
    for (int k = 0; k < 160; k++) send(1'b1, 2047);

    // R7/R8: sign-matched full-scale blocks
    pad_group();
    cur_req = "R7 positive clamp";
    for (int k = 0; k < NT; k++) send(1'b1, (bcoef(NT - 1 - k) >= 0) ? 2047 : -2048);
    cur_req = "R8 negative clamp";
    for (int k = 0; k < NT; k++) send(1'b1, (bcoef(NT - 1 - k) >= 0) ? -2048 : 2047);
    repeat (3) send(1'b0, 0);
    pad_group();

    // R3: random gaps with garbage on idle cycles
    cur_req = "R3 random gaps";
    run_random(1200);
    repeat (4) send(1'b0, 0);

    // R9: reset in mid-group, then fresh history
    for (int k = 0; k < 5; k++) send(1'b1, 1500);
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R9 cleared after reset", out_data, 0);
    cur_req = "R9 after reset";
    run_random(60);
    cur_req = "R1 restart";
    run_random(400);
    repeat (6) send(1'b0, 0);
    check(head == tail, "R2 all outputs seen", tail - head, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule